// File: doc/BRIEF.md
# Privilege-Gated Timer Compare Register

This block holds the compare value of one physical timer channel and raises a timer condition when a free-running counter reaches it. Software reaches the value through a system-register port: each access carries a 16-bit encoding, a read/write flag and write data. The access context travels alongside it: privilege level, security state, the low bit of the effective nested-virtualization control and the secure level-2 enable. A decoder judges that context and returns one of three outcomes: the access is performed, it is reported as undefined, or it traps to level 2 with a syndrome class.

The stored value may be narrower than 64 bits when the counter is narrower. It is then zero-extended both on read-back and in the comparison. The counter itself and the routing of the condition to an interrupt controller are outside this block.

Top module: `tcmp_reg`

## Requirements
- R1: Only the encoding 16'hE72A is answered. Its fields, from the most significant bit down, are op0=2'b11, op1=3'b100, CRn=4'b1110, CRm=4'b0101 and op2=3'b010. Any other encoding gives no response (rsp_valid stays 0) and leaves the stored value unchanged.
- R2: Any access from privilege level 0 is reported as undefined.
- R3: At level 1, a non-secure access is undefined. A secure access with nv_trap_en=1 sets rsp_trap with rsp_ec=6'h18 and clears rsp_undef. A secure access with nv_trap_en=0 is undefined.
- R4: At level 2, an access is performed when sec_state=1 and is undefined when sec_state=0.
- R5: At level 3, an access is undefined when sel2_en=0 and is performed when sel2_en=1, whatever the security state.
- R6: Every matching access gets exactly one response cycle, one clock edge after the access. rsp_undef and rsp_trap are never both set. rsp_rdata carries the stored value for a performed read and is zero for writes and for refused accesses.
- R7: A write that is refused (undefined or trapped) leaves the stored value unchanged.
- R8: The value is stored at CNT_W bits. Write-data bits at CNT_W and above are dropped, and those bits of rsp_rdata read as zero.
- R9: cond_met is 1 exactly when tmr_enable=1 and the unsigned cnt_value is greater than or equal to the zero-extended stored value. It follows tmr_enable and cnt_value in the same cycle.
- R10: A performed write takes effect at the clock edge that accepts it. cond_met reflects the new value from that edge on, and still reflects the old value before it.
- R11: Synchronous active-high reset clears the stored value to zero and the response outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | System-register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_enc | input | 16 | Access encoding {op0, op1, CRn, CRm, op2} |
| acc_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| sec_state | input | 1 | 1 = secure state |
| nv_trap_en | input | 1 | Bit 0 of the effective nested-virtualization control |
| sel2_en | input | 1 | Secure level-2 enable, as seen from level 3 |
| tmr_enable | input | 1 | Enable bit of the timer control |
| cnt_value | input | CNT_W | Free-running counter value |
| rsp_valid | output | 1 | Response to a matching access |
| rsp_rdata | output | 64 | Read data, zero-extended |
| rsp_undef | output | 1 | Access reported as undefined |
| rsp_trap | output | 1 | Access traps to level 2 |
| rsp_ec | output | 6 | Syndrome class of the trap, 6'h18 when rsp_trap is set |
| cond_met | output | 1 | Timer condition met |

## Verification
The access outcome and the read data are registered, so their results are due one edge after the access. The bench drives each access on a falling edge and samples the response on the next falling edge, after exactly one rising edge. cond_met is combinational in the counter and enable, so it is sampled a few nanoseconds after those inputs change, inside the same cycle. For the write-to-condition timing, the bench samples once before the accepting edge and once after it, which shows the old and the new compare value in turn.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    // Encoding fields, most significant first: op0, op1, CRn, CRm, op2
    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam sysenc_t TCMP_ENC = '{op0: 2'b11, op1: 3'b100, crn: 4'b1110,
                                     crm: 4'b0101, op2: 3'b010};
    localparam logic [5:0] EC_SYSREG_TRAP = 6'h18;
    localparam int unsigned DATA_W = 64;

    typedef enum logic [1:0] {
        PL0 = 2'd0,
        PL1 = 2'd1,
        PL2 = 2'd2,
        PL3 = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_OK    = 2'd0,
        ACC_UNDEF = 2'd1,
        ACC_TRAP  = 2'd2
    } verdict_e;

    typedef struct packed {
        priv_e prv;
        logic  secure;
        logic  nv_trap;
        logic  sel2_en;
    } ctx_t;

    typedef struct packed {
        logic       valid;
        logic       undef;
        logic       trap;
        logic [5:0] ec;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    function automatic logic enc_match(sysenc_t e);
        return (e.op0 == TCMP_ENC.op0) && (e.op1 == TCMP_ENC.op1) &&
               (e.crn == TCMP_ENC.crn) && (e.crm == TCMP_ENC.crm) &&
               (e.op2 == TCMP_ENC.op2);
    endfunction

    function automatic verdict_e judge(ctx_t c);
        verdict_e v;
        unique case (c.prv)
            PL0: v = ACC_UNDEF;
            PL1: begin
                if (!c.secure)      v = ACC_UNDEF;
                else if (c.nv_trap) v = ACC_TRAP;
                else                v = ACC_UNDEF;
            end
            PL2: v = c.secure  ? ACC_OK : ACC_UNDEF;
            PL3: v = c.sel2_en ? ACC_OK : ACC_UNDEF;
            default: v = ACC_UNDEF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tcmp_access_dec.sv
module tcmp_access_dec
    import tcmp_pkg::*;
(
    input  logic     acc_valid,
    input  logic     acc_write,
    input  sysenc_t  enc,
    input  ctx_t     ctx,
    output logic     hit,
    output logic     wr_en,
    output logic     rd_en,
    output verdict_e verdict
);

    always_comb begin
        hit     = acc_valid && enc_match(enc);
        verdict = judge(ctx);
        wr_en   = hit && acc_write  && (verdict == ACC_OK);
        rd_en   = hit && !acc_write && (verdict == ACC_OK);
    end

endmodule

// File: rtl/tcmp_cval_store.sv
module tcmp_cval_store
    import tcmp_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cval,
    output logic [DATA_W-1:0] cval_ext
);

    localparam int unsigned PAD_W = DATA_W - CNT_W;

    always_ff @(posedge clk) begin
        if (rst)        cval <= '0;
        else if (wr_en) cval <= wdata[CNT_W-1:0];
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign cval_ext = {{PAD_W{1'b0}}, cval};
        end else begin : g_full
            assign cval_ext = cval;
        end
    endgenerate

endmodule

// File: rtl/tcmp_compare.sv
module tcmp_compare #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             enable,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cval,
    output logic             met
);

    always_comb begin
        met = enable && (cnt >= cval);
    end

endmodule

// File: rtl/tcmp_reg.sv
module tcmp_reg
    import tcmp_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [15:0]       acc_enc,
    input  logic [63:0]       acc_wdata,
    input  logic [1:0]        priv_lvl,
    input  logic              sec_state,
    input  logic              nv_trap_en,
    input  logic              sel2_en,
    input  logic              tmr_enable,
    input  logic [CNT_W-1:0]  cnt_value,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic [5:0]        rsp_ec,
    output logic              cond_met
);

    ctx_t            ctx;
    logic            hit;
    logic            wr_en;
    logic            rd_en;
    verdict_e        verdict;
    logic [CNT_W-1:0]  cval;
    logic [DATA_W-1:0] cval_ext;
    rsp_t            rsp_d;
    rsp_t            rsp_q;

    always_comb begin
        ctx.prv     = priv_e'(priv_lvl);
        ctx.secure  = sec_state;
        ctx.nv_trap = nv_trap_en;
        ctx.sel2_en = sel2_en;
    end

    tcmp_access_dec u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .enc       (sysenc_t'(acc_enc)),
        .ctx       (ctx),
        .hit       (hit),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .verdict   (verdict)
    );

    tcmp_cval_store #(.CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wdata    (acc_wdata),
        .cval     (cval),
        .cval_ext (cval_ext)
    );

    tcmp_compare #(.CNT_W(CNT_W)) u_cmp (
        .enable (tmr_enable),
        .cnt    (cnt_value),
        .cval   (cval),
        .met    (cond_met)
    );

    always_comb begin
        rsp_d.valid = hit;
        rsp_d.undef = hit && (verdict == ACC_UNDEF);
        rsp_d.trap  = hit && (verdict == ACC_TRAP);
        rsp_d.ec    = (hit && (verdict == ACC_TRAP)) ? EC_SYSREG_TRAP : 6'h00;
        rsp_d.rdata = rd_en ? cval_ext : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_undef = rsp_q.undef;
    assign rsp_trap  = rsp_q.trap;
    assign rsp_ec    = rsp_q.ec;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/tcmp_reg_chk.sv
module tcmp_reg_chk
    import tcmp_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic [15:0]      acc_enc,
    input logic [1:0]       priv_lvl,
    input logic             sec_state,
    input logic             nv_trap_en,
    input logic             sel2_en,
    input logic             tmr_enable,
    input logic             rsp_valid,
    input logic [63:0]      rsp_rdata,
    input logic             rsp_undef,
    input logic             rsp_trap,
    input logic [5:0]       rsp_ec,
    input logic             cond_met
);

    logic sel;
    assign sel = acc_valid && (acc_enc == 16'hE72A);

    // R1
    miss_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_enc != 16'hE72A) |=> !rsp_valid);

    // R2
    pl0_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && priv_lvl == 2'd0) |=> (rsp_valid && rsp_undef && !rsp_trap));

    // R3
    pl1_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && priv_lvl == 2'd1 && sec_state && nv_trap_en)
        |=> (rsp_trap && rsp_ec == 6'h18 && !rsp_undef));

    // R4
    pl2_nonsec_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && priv_lvl == 2'd2 && !sec_state) |=> rsp_undef);

    // R5
    pl3_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && priv_lvl == 2'd3) |=> (rsp_undef == !$past(sel2_en)));

    // R6
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_undef && rsp_trap));

    // R6
    refused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_undef || rsp_trap) |-> (rsp_rdata == 64'd0));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_enable |-> !cond_met);

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && rsp_rdata == 64'd0));

    generate
        if (CNT_W < 64) begin : g_narrow
            // R8
            upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
                rsp_rdata[63:CNT_W] == '0);
        end
    endgenerate

endmodule

bind tcmp_reg tcmp_reg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_enc    (acc_enc),
    .priv_lvl   (priv_lvl),
    .sec_state  (sec_state),
    .nv_trap_en (nv_trap_en),
    .sel2_en    (sel2_en),
    .tmr_enable (tmr_enable),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_undef  (rsp_undef),
    .rsp_trap   (rsp_trap),
    .rsp_ec     (rsp_ec),
    .cond_met   (cond_met)
);

// File: tb/tcmp_reg_bench.sv
module tcmp_reg_bench;

    localparam int CW = 48;
    localparam logic [63:0] MASK = (64'd1 << CW) - 64'd1;
    localparam logic [15:0] ENC_HIT = 16'hE72A;

    // expected outcome codes: 0 performed, 1 undefined, 2 trap
    typedef struct packed {
        logic [1:0]  prv;
        logic        sec;
        logic        nv;
        logic        sel2;
        logic        wr;
        logic [63:0] wd;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0011, 2'd1},
        '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0,                   2'd1},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_0022, 2'd1},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_0033, 2'd2},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0,                   2'd1},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0044, 2'd1},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 64'hFFFF_0000_1234_5678, 2'd0},
        '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0,                   2'd0},
        '{2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0055, 2'd1},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0,                   2'd0},
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_00AB_CDEF_0000, 2'd0},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0,                   2'd2},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_0066, 2'd2},
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0,                   2'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [15:0]   acc_enc = 16'h0;
    logic [63:0]   acc_wdata = 64'h0;
    logic [1:0]    priv_lvl = 2'd0;
    logic          sec_state = 1'b0;
    logic          nv_trap_en = 1'b0;
    logic          sel2_en = 1'b0;
    logic          tmr_enable = 1'b0;
    logic [CW-1:0] cnt_value = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          rsp_undef;
    logic          rsp_trap;
    logic [5:0]    rsp_ec;
    logic          cond_met;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    logic [63:0] model = 64'h0;

    always #10 clk = ~clk;

    tcmp_reg #(.CNT_W(CW)) u_tcmp_reg (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_enc(acc_enc), .acc_wdata(acc_wdata), .priv_lvl(priv_lvl),
        .sec_state(sec_state), .nv_trap_en(nv_trap_en), .sel2_en(sel2_en),
        .tmr_enable(tmr_enable), .cnt_value(cnt_value), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
        .rsp_ec(rsp_ec), .cond_met(cond_met)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on a falling edge; the response is sampled on the next falling edge.
    task automatic access(input logic [15:0] enc, input logic [1:0] prv,
                          input logic sec, input logic nv, input logic s2,
                          input logic wr, input logic [63:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_enc = enc; priv_lvl = prv; sec_state = sec;
        nv_trap_en = nv; sel2_en = s2; acc_write = wr; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic read_back(input string req, input logic [63:0] exp);
        access(ENC_HIT, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0);
        check(req, rsp_rdata, exp);
    endtask

    task automatic write_ok(input logic [63:0] wd);
        access(ENC_HIT, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, wd);
        model = wd & MASK;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        tmr_enable = 1'b1; cnt_value = '0;
        #2 check("R11 cond_met with zero compare", {63'd0, cond_met}, 64'd1);
        read_back("R11 value after reset", 64'd0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            access(ENC_HIT, VECS[i].prv, VECS[i].sec, VECS[i].nv, VECS[i].sel2,
                   VECS[i].wr, VECS[i].wd);
            check("R6 rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check("R2/R3/R4/R5 undef", {63'd0, rsp_undef}, {63'd0, VECS[i].exp == 2'd1});
            check("R3 trap", {63'd0, rsp_trap}, {63'd0, VECS[i].exp == 2'd2});
            check("R3 syndrome", {58'd0, rsp_ec}, (VECS[i].exp == 2'd2) ? 64'h18 : 64'h0);
            if (VECS[i].exp == 2'd0 && VECS[i].wr) model = VECS[i].wd & MASK;
            check("R6 R7 R8 rdata",  rsp_rdata,
                  (VECS[i].exp == 2'd0 && !VECS[i].wr) ? model : 64'h0);
        end
        read_back("R7 refused writes left value", model);

        // R1: other encodings are ignored
        access(16'hE72B, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 64'h77);
        check("R1 no response on op2 mismatch", {63'd0, rsp_valid}, 64'd0);
        access(16'h672A, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 64'h88);
        check("R1 no response on op0 mismatch", {63'd0, rsp_valid}, 64'd0);
        read_back("R1 value unchanged", model);

        // R9: comparison thresholds
        write_ok(64'd1000);
        @(negedge clk); tmr_enable = 1'b1; cnt_value = 48'd999;
        #2 check("R9 below compare", {63'd0, cond_met}, 64'd0);
        @(negedge clk); cnt_value = 48'd1000;
        #2 check("R9 equal compare", {63'd0, cond_met}, 64'd1);
        @(negedge clk); cnt_value = 48'd1001;
        #2 check("R9 above compare", {63'd0, cond_met}, 64'd1);
        @(negedge clk); tmr_enable = 1'b0;
        #2 check("R9 disabled", {63'd0, cond_met}, 64'd0);

        // R10: new value seen only after the accepting edge
        @(negedge clk); tmr_enable = 1'b1; cnt_value = 48'd500;
        acc_valid = 1'b1; acc_write = 1'b1; acc_enc = ENC_HIT; priv_lvl = 2'd2;
        sec_state = 1'b1; acc_wdata = 64'd400;
        #2 check("R10 old value before edge", {63'd0, cond_met}, 64'd0);
        @(negedge clk); acc_valid = 1'b0; acc_write = 1'b0; model = 64'd400;
        check("R10 new value after edge", {63'd0, cond_met}, 64'd1);

        // R8: widest value and unsigned compare at the top of the range
        write_ok(64'hFFFF_FFFF_FFFF_FFFF);
        read_back("R8 upper bits zero", 64'h0000_FFFF_FFFF_FFFF);
        @(negedge clk); cnt_value = 48'hFFFF_FFFF_FFFE;
        #2 check("R8 R9 max minus one", {63'd0, cond_met}, 64'd0);
        @(negedge clk); cnt_value = 48'hFFFF_FFFF_FFFF;
        #2 check("R8 R9 max", {63'd0, cond_met}, 64'd1);

        // R11: reset during operation clears the value
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_back("R11 cleared by reset", 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule